// File: doc/BRIEF.md
# NAND Page Array with Spare Area

This block is an on-chip storage array that behaves like NAND cells. Storage is split into pages. Each page carries a data area and a spare area. Pages are grouped into erase blocks. A command sequencer drives three request strobes: load, program and erase. Each request comes with a page address and a starting column. Bytes to be programmed are first streamed into a write buffer. Bytes produced by a load are drained from a readout buffer one per read strobe.

Programming can only clear bits, because each buffered byte is ANDed into the stored byte. Only an erase brings bits back to one, and an erase always covers a whole multi-page block. Each operation walks one byte per cycle. When it ends, the block raises a one-cycle done pulse. There is no busy output: the sequencer waits for done. If more than one strobe is raised in the same cycle, erase wins over program, and program wins over load.

Top module: `nand_page_array`

## Requirements
- R1: After reset every byte of every page reads 0xFF, `done` is 0 and `rd_data` is 0x00.
- R2: A page holds PAGE_BYTES data bytes followed by PAGE_BYTES/32 spare bytes. With the default of 64, a page has 66 columns: 0..63 are data and 64..65 are spare.
- R3: A program ANDs buffered byte i into column col+i of the addressed page. A stored 0 bit never returns to 1 through programming.
- R4: An erase addressed to any page of a block sets every data and spare byte of all PAGES_PER_BLOCK pages to 0xFF. A block starts at a page number that is a multiple of PAGES_PER_BLOCK. Other blocks are untouched.
- R5: A load copies the page starting at column col. The readable length is TOTAL−col, or PAGE_BYTES−col when `spare_off` is 1. The length is 0 when col is at or past that limit. An accepted load empties the readout buffer in the cycle it is taken.
- R6: Once TOTAL bytes are buffered, further write bytes are dropped. A buffered byte whose target column col+i is TOTAL or more is not stored.
- R7: A request whose page is NUM_PAGES or above ends with `done` after one cycle. It leaves the array unchanged, keeps the buffered write bytes for the next program, and leaves the readout position and length unchanged.
- R8: `rd_data` shows the next readout byte. A cycle with `rd_en` advances to the following byte and shortens the remaining length by one. With no bytes left, `rd_data` is 0x00 and `rd_en` has no effect.
- R9: `done` is high for exactly one cycle, L cycles after the edge that accepts the request. L = max(n,1), where n is the load length, the buffered byte count, or PAGES_PER_BLOCK×TOTAL for an erase.
- R10: While an operation is in progress, new request strobes and `wr_valid` bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; fills the array with 0xFF |
| req_load | input | 1 | Load strobe |
| req_prog | input | 1 | Program strobe |
| req_erase | input | 1 | Erase strobe |
| req_page | input | $clog2(PAGES_PER_BLOCK*NUM_BLOCKS)+1 | Page address; the top bit allows out-of-range values |
| req_col | input | $clog2(PAGE_BYTES+PAGE_BYTES/32)+1 | Starting column for load and program |
| spare_off | input | 1 | On a load, stop the readable length at the end of the data area |
| wr_valid | input | 1 | Write byte strobe into the write buffer |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Advance the readout buffer by one byte |
| rd_data | output | 8 | Current readout byte, 0x00 when none is left |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
A corrupted cell, or a program that overwrites instead of ANDs, is not visible until the page is loaded again. After that load, the wrong byte appears on `rd_data` at exactly its column position in the drain. A wrong operation length or a lost request shows up at once as `done` arriving in the wrong cycle, because the bench predicts the done cycle for every request. A readout pointer or length that has gone wrong shows on the very next byte, or on a 0x00 that arrives too early or too late at the end of the drain.

// File: rtl/nand_pa_pkg.sv
package nand_pa_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;

  // spare bytes that follow the data area of one page
  function automatic int spare_of(input int page_bytes);
    return page_bytes / 32;
  endfunction

  // number of readable bytes for a load starting at col
  function automatic int load_len(input int col, input int page_bytes, input bit no_spare);
    int lim;
    lim = no_spare ? page_bytes : page_bytes + spare_of(page_bytes);
    return (col >= lim) ? 0 : lim - col;
  endfunction

  // first page of the erase block holding page
  function automatic int block_first_page(input int page, input int pages_per_block);
    return (page / pages_per_block) * pages_per_block;
  endfunction

endpackage

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
  parameter int MEM_BYTES = 1056,
  parameter int AW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [8*MEM_BYTES-1:0] flat;

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= 8'hFF;
      end else if (we && (int'(waddr) == g)) begin
        q <= wdata;
      end
    end
    assign flat[g*8 +: 8] = q;
  end

  always_comb begin
    if (int'(raddr) < MEM_BYTES) rdata = flat[{raddr, 3'b000} +: 8];
    else                         rdata = 8'hFF;
  end

  // R7: the controller never writes outside the array
  a_r7_write_in_array: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < MEM_BYTES));

endmodule

// File: rtl/nand_wr_buf.sv
module nand_wr_buf #(
  parameter int DEPTH = 66,
  parameter int WCW   = 7,
  parameter int CW    = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [7:0]     byte_in,
  input  logic           clear,
  input  logic [CW-1:0]  rd_idx,
  output logic [7:0]     rd_byte,
  output logic [WCW-1:0] count
);

  localparam int IW = $clog2(DEPTH);

  logic [7:0] store [DEPTH];
  logic       room;

  assign room = int'(count) < DEPTH;

  always_ff @(posedge clk) begin
    if (push && room) store[count[IW-1:0]] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (push && room) begin
      count <= count + WCW'(1);
    end
  end

  always_comb begin
    if (int'(rd_idx) < DEPTH) rd_byte = store[rd_idx[IW-1:0]];
    else                      rd_byte = 8'hFF;
  end

  // R6: the buffer never holds more than one full page with spare
  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R6: a full buffer drops further bytes
  a_r6_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!room && !clear) |=> $stable(count));

endmodule

// File: rtl/nand_rd_buf.sv
module nand_rd_buf #(
  parameter int DEPTH = 66,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          invalidate,
  input  logic          fill,
  input  logic [CW-1:0] fill_idx,
  input  logic [7:0]    fill_byte,
  input  logic          arm,
  input  logic [CW-1:0] arm_len,
  input  logic          rd_en,
  output logic [7:0]    rd_data
);

  localparam int IW = $clog2(DEPTH);

  logic [7:0]    store [DEPTH];
  logic [CW-1:0] ptr;
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (fill && (int'(fill_idx) < DEPTH)) store[fill_idx[IW-1:0]] <= fill_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      remain <= '0;
    end else if (invalidate) begin
      ptr    <= '0;
      remain <= '0;
    end else if (arm) begin
      ptr    <= '0;
      remain <= arm_len;
    end else if (rd_en && (remain != '0)) begin
      ptr    <= ptr + CW'(1);
      remain <= remain - CW'(1);
    end
  end

  always_comb begin
    if ((remain != '0) && (int'(ptr) < DEPTH)) rd_data = store[ptr[IW-1:0]];
    else                                       rd_data = 8'h00;
  end

  // R8: a read with bytes left shortens the length by exactly one
  a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (remain != '0) && !invalidate && !arm) |=> (remain == $past(remain) - CW'(1)));

  // R5: the readable length never exceeds one page with spare
  a_r5_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(remain) <= DEPTH);

endmodule

// File: rtl/nand_op_ctrl.sv
module nand_op_ctrl
  import nand_pa_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int TOTAL      = 66,
  parameter int PPB        = 4,
  parameter int NUM_PAGES  = 16,
  parameter int PG_W       = 5,
  parameter int COL_W      = 8,
  parameter int AW         = 11,
  parameter int CW         = 9,
  parameter int WCW        = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_load,
  input  logic             req_prog,
  input  logic             req_erase,
  input  logic [PG_W-1:0]  req_page,
  input  logic [COL_W-1:0] req_col,
  input  logic             spare_off,
  input  logic [WCW-1:0]   wcount,
  output logic             idle,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [7:0]       mem_wdata,
  output logic [AW-1:0]    mem_raddr,
  input  logic [7:0]       mem_rdata,
  output logic [CW-1:0]    wbuf_idx,
  input  logic [7:0]       wbuf_byte,
  output logic             wbuf_clear,
  output logic             rb_invalidate,
  output logic             rb_fill,
  output logic [CW-1:0]    rb_fill_idx,
  output logic [7:0]       rb_fill_byte,
  output logic             rb_arm,
  output logic [CW-1:0]    rb_arm_len,
  output logic             done
);

  localparam int MEM_BYTES = NUM_PAGES * TOTAL;

  logic             busy_q;
  op_e              op_q;
  logic [CW-1:0]    idx_q;
  logic [CW-1:0]    len_q;
  logic [AW-1:0]    base_q;
  logic [COL_W-1:0] col_q;
  logic             done_q;

  logic             any_req;
  logic             in_range;
  op_e              req_op;
  logic             step;
  logic             last;
  logic [31:0]      tcol;
  logic [31:0]      raddr_w;

  always_comb begin
    any_req  = req_load | req_prog | req_erase;
    in_range = int'(req_page) < NUM_PAGES;
    if (req_erase)      req_op = OP_ERASE;
    else if (req_prog)  req_op = OP_PROG;
    else if (req_load)  req_op = OP_LOAD;
    else                req_op = OP_NONE;
  end

  always_comb begin
    step    = busy_q && (idx_q < len_q);
    last    = busy_q && ((32'(idx_q) + 32'd1) >= 32'(len_q));
    tcol    = (op_q == OP_ERASE) ? 32'(idx_q) : (32'(col_q) + 32'(idx_q));
    raddr_w = 32'(base_q) + tcol;
  end

  assign mem_raddr     = AW'(raddr_w);
  assign mem_waddr     = AW'(raddr_w);
  assign mem_we        = step && ((op_q == OP_ERASE) ||
                                  ((op_q == OP_PROG) && (tcol < 32'(TOTAL))));
  assign mem_wdata     = (op_q == OP_ERASE) ? 8'hFF : (mem_rdata & wbuf_byte);
  assign wbuf_idx      = idx_q;
  assign wbuf_clear    = last && (op_q == OP_PROG);
  assign rb_invalidate = !busy_q && (req_op == OP_LOAD) && in_range;
  assign rb_fill       = step && (op_q == OP_LOAD);
  assign rb_fill_idx   = idx_q;
  assign rb_fill_byte  = mem_rdata;
  assign rb_arm        = last && (op_q == OP_LOAD);
  assign rb_arm_len    = len_q;
  assign idle          = !busy_q;
  assign done          = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      idx_q  <= '0;
      len_q  <= '0;
      base_q <= '0;
      col_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (!busy_q) begin
        if (any_req) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          col_q  <= req_col;
          if (!in_range) begin
            op_q   <= OP_NONE;
            len_q  <= '0;
            base_q <= '0;
          end else begin
            op_q <= req_op;
            case (req_op)
              OP_ERASE: begin
                base_q <= AW'(block_first_page(int'(req_page), PPB) * TOTAL);
                len_q  <= CW'(PPB * TOTAL);
              end
              OP_PROG: begin
                base_q <= AW'(int'(req_page) * TOTAL);
                len_q  <= CW'(wcount);
              end
              default: begin
                base_q <= AW'(int'(req_page) * TOTAL);
                len_q  <= CW'(load_len(int'(req_col), PAGE_BYTES, spare_off));
              end
            endcase
          end
        end
      end else begin
        if (step) idx_q <= idx_q + CW'(1);
        if (last) begin
          busy_q <= 1'b0;
          op_q   <= OP_NONE;
        end
      end
    end
  end

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: done is only seen once the controller is free again
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R10: an operation in progress keeps its parameters despite new strobes
  a_r10_params_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> ($stable(len_q) && $stable(base_q) && $stable(col_q) && busy_q));

  // R7: writes stay inside the array
  a_r7_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_waddr) < MEM_BYTES));

endmodule

// File: rtl/nand_page_array.sv
module nand_page_array
  import nand_pa_pkg::*;
#(
  parameter int  PAGE_BYTES      = 64,
  parameter int  PAGES_PER_BLOCK = 4,
  parameter int  NUM_BLOCKS      = 4,
  localparam int PG_W            = $clog2(PAGES_PER_BLOCK * NUM_BLOCKS) + 1,
  localparam int COL_W           = $clog2(PAGE_BYTES + PAGE_BYTES / 32) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_load,
  input  logic             req_prog,
  input  logic             req_erase,
  input  logic [PG_W-1:0]  req_page,
  input  logic [COL_W-1:0] req_col,
  input  logic             spare_off,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             done
);

  localparam int TOTAL       = PAGE_BYTES + spare_of(PAGE_BYTES);
  localparam int NUM_PAGES   = PAGES_PER_BLOCK * NUM_BLOCKS;
  localparam int BLOCK_BYTES = PAGES_PER_BLOCK * TOTAL;
  localparam int MEM_BYTES   = NUM_PAGES * TOTAL;
  localparam int AW          = $clog2(MEM_BYTES);
  localparam int CW          = $clog2(BLOCK_BYTES + 1);
  localparam int WCW         = $clog2(TOTAL + 1);

  logic           idle;
  logic           mem_we;
  logic [AW-1:0]  mem_waddr;
  logic [7:0]     mem_wdata;
  logic [AW-1:0]  mem_raddr;
  logic [7:0]     mem_rdata;
  logic [CW-1:0]  wbuf_idx;
  logic [7:0]     wbuf_byte;
  logic           wbuf_clear;
  logic [WCW-1:0] wcount;
  logic           rb_invalidate;
  logic           rb_fill;
  logic [CW-1:0]  rb_fill_idx;
  logic [7:0]     rb_fill_byte;
  logic           rb_arm;
  logic [CW-1:0]  rb_arm_len;
  logic           wr_accept;

  assign wr_accept = wr_valid && idle;

  nand_op_ctrl #(
    .PAGE_BYTES (PAGE_BYTES),
    .TOTAL      (TOTAL),
    .PPB        (PAGES_PER_BLOCK),
    .NUM_PAGES  (NUM_PAGES),
    .PG_W       (PG_W),
    .COL_W      (COL_W),
    .AW         (AW),
    .CW         (CW),
    .WCW        (WCW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_load      (req_load),
    .req_prog      (req_prog),
    .req_erase     (req_erase),
    .req_page      (req_page),
    .req_col       (req_col),
    .spare_off     (spare_off),
    .wcount        (wcount),
    .idle          (idle),
    .mem_we        (mem_we),
    .mem_waddr     (mem_waddr),
    .mem_wdata     (mem_wdata),
    .mem_raddr     (mem_raddr),
    .mem_rdata     (mem_rdata),
    .wbuf_idx      (wbuf_idx),
    .wbuf_byte     (wbuf_byte),
    .wbuf_clear    (wbuf_clear),
    .rb_invalidate (rb_invalidate),
    .rb_fill       (rb_fill),
    .rb_fill_idx   (rb_fill_idx),
    .rb_fill_byte  (rb_fill_byte),
    .rb_arm        (rb_arm),
    .rb_arm_len    (rb_arm_len),
    .done          (done)
  );

  nand_cell_array #(
    .MEM_BYTES (MEM_BYTES),
    .AW        (AW)
  ) u_cells (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  nand_wr_buf #(
    .DEPTH (TOTAL),
    .WCW   (WCW),
    .CW    (CW)
  ) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (wr_accept),
    .byte_in (wr_data),
    .clear   (wbuf_clear),
    .rd_idx  (wbuf_idx),
    .rd_byte (wbuf_byte),
    .count   (wcount)
  );

  nand_rd_buf #(
    .DEPTH (TOTAL),
    .CW    (CW)
  ) u_rbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .invalidate (rb_invalidate),
    .fill       (rb_fill),
    .fill_idx   (rb_fill_idx),
    .fill_byte  (rb_fill_byte),
    .arm        (rb_arm),
    .arm_len    (rb_arm_len),
    .rd_en      (rd_en),
    .rd_data    (rd_data)
  );

  // R10: write bytes offered during an operation leave the buffer count alone
  a_r10_wr_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !wbuf_clear) |=> $stable(wcount));

endmodule

// File: tb/sim_nand_page_array.sv
module sim_nand_page_array;

  localparam int PB   = 64;
  localparam int PPB  = 4;
  localparam int NB   = 4;
  localparam int TOT  = PB + PB / 32;
  localparam int NP   = PPB * NB;
  localparam int PGW  = $clog2(NP) + 1;
  localparam int COLW = $clog2(TOT) + 1;

  logic            clk;
  logic            rst_n;
  logic            req_load, req_prog, req_erase;
  logic [PGW-1:0]  req_page;
  logic [COLW-1:0] req_col;
  logic            spare_off;
  logic            wr_valid;
  logic [7:0]      wr_data;
  logic            rd_en;
  logic [7:0]      rd_data;
  logic            done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  nand_page_array #(.PAGE_BYTES(PB), .PAGES_PER_BLOCK(PPB), .NUM_BLOCKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_prog(req_prog),
    .req_erase(req_erase), .req_page(req_page), .req_col(req_col),
    .spare_off(spare_off), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .done(done)
  );

  // ---------------- behavioural reference model ----------------
  int mm [TOT*NP];
  int wq [$];
  int rbm [TOT];
  int rptr_m, rlen_m;
  int busy_m, cnt_m, op_m, pg_m, col_m, len_m;
  bit exp_done;
  bit m_skip_rd;
  bit was_idle;

  function automatic int m_len(input int col, input bit so);
    int lim;
    lim = so ? PB : TOT;
    return (col >= lim) ? 0 : lim - col;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOT*NP; i++) mm[i] = 255;
      wq.delete();
      rptr_m = 0; rlen_m = 0; busy_m = 0; cnt_m = 0; op_m = 0;
      pg_m = 0; col_m = 0; len_m = 0; exp_done = 0;
    end else begin
      exp_done  = 0;
      m_skip_rd = 0;
      was_idle  = (busy_m == 0);
      if (busy_m != 0) begin
        cnt_m--;
        if (cnt_m == 0) begin
          busy_m   = 0;
          exp_done = 1;
          if (op_m == 1) begin
            for (int i = 0; i < len_m; i++) rbm[i] = mm[pg_m*TOT + col_m + i];
            rlen_m = len_m; rptr_m = 0; m_skip_rd = 1;
          end else if (op_m == 2) begin
            for (int i = 0; i < wq.size(); i++)
              if (col_m + i < TOT) mm[pg_m*TOT + col_m + i] &= wq[i];
            wq.delete();
          end else if (op_m == 3) begin
            for (int i = 0; i < PPB*TOT; i++) mm[(pg_m/PPB)*PPB*TOT + i] = 255;
          end
        end
      end else if (req_load || req_prog || req_erase) begin
        pg_m = int'(req_page); col_m = int'(req_col); busy_m = 1;
        if (pg_m >= NP) begin op_m = 0; len_m = 0; end
        else if (req_erase) begin op_m = 3; len_m = PPB*TOT; end
        else if (req_prog) begin op_m = 2; len_m = wq.size(); end
        else begin
          op_m = 1; len_m = m_len(col_m, spare_off);
          rlen_m = 0; rptr_m = 0; m_skip_rd = 1;
        end
        cnt_m = (len_m < 1) ? 1 : len_m;
      end
      if (was_idle && wr_valid && wq.size() < TOT) wq.push_back(int'(wr_data));
      if (!m_skip_rd && rd_en && rlen_m > 0) begin rptr_m++; rlen_m--; end
    end
  end

  // compare outputs with the model on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (int'(rd_data) !== ((rlen_m > 0) ? rbm[rptr_m] : 0)) begin
        errors++;
        $display("FAIL R8 model rd_data actual %0h expected %0h", rd_data,
                 (rlen_m > 0) ? rbm[rptr_m] : 0);
      end
      checks++;
      if (done !== exp_done) begin
        errors++;
        $display("FAIL R9 model done actual %0b expected %0b", done, exp_done);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input int b);
    wr_valid = 1'b1; wr_data = 8'(b);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(output int v);
    v = int'(rd_data);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_req(input int kind, input int page, input int col, input bit so, output int lat);
    req_page = PGW'(page); req_col = COLW'(col); spare_off = so;
    if (kind == 1) req_load = 1'b1;
    else if (kind == 2) req_prog = 1'b1;
    else req_erase = 1'b1;
    @(negedge clk);
    req_load = 1'b0; req_prog = 1'b0; req_erase = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
  endtask

  function automatic int pa(input int i);
    return (i*37 + 11) & 255;
  endfunction
  function automatic int pb(input int j);
    return ((j*53) ^ 90) & 255;
  endfunction
  function automatic int exp5(input int c);
    return pa(c) & (((c >= 3) && (c < 13)) ? pb(c - 3) : 255);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8*150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lat, v;
    rst_n = 1'b0; req_load = 0; req_prog = 0; req_erase = 0; req_page = '0;
    req_col = '0; spare_off = 0; wr_valid = 0; wr_data = '0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 rd_data after reset", int'(rd_data), 0);

    // R1 / R2: erased page, full length is data plus spare
    do_req(1, 0, 0, 0, lat);
    chk("R9 load latency full page", lat, TOT);
    for (int i = 0; i < TOT; i++) begin rd(v); chk("R1 reset byte FF", v, 255); end
    rd(v); chk("R2 length ends after spare", v, 0);
    rd(v); chk("R8 empty read stays 0", v, 0);

    // R3 / R6: two overlapping programs on page 5
    for (int i = 0; i < TOT + 4; i++) push(pa(i));
    do_req(2, 5, 0, 0, lat);
    chk("R6 buffer capped at page size", lat, TOT);
    for (int j = 0; j < 10; j++) push(pb(j));
    do_req(2, 5, 3, 0, lat);
    chk("R9 program latency", lat, 10);
    do_req(1, 5, 0, 0, lat);
    for (int c = 0; c < TOT; c++) begin rd(v); chk("R3 AND of both programs", v, exp5(c)); end

    // R6: program running past the spare area
    for (int i = 0; i < 8; i++) push(8'h30 + i);
    do_req(2, 6, 62, 0, lat);
    do_req(1, 6, 60, 0, lat);
    chk("R5 load latency from column", lat, 6);
    for (int c = 60; c < TOT; c++) begin
      rd(v); chk("R6 tail program", v, (c < 62) ? 255 : (8'h30 + c - 62));
    end
    rd(v); chk("R8 zero after tail", v, 0);

    // R5: spare suppressed
    do_req(1, 5, 10, 1, lat);
    chk("R5 data only length", lat, PB - 10);
    for (int c = 10; c < PB; c++) begin rd(v); chk("R5 data only byte", v, exp5(c)); end
    rd(v); chk("R5 no spare byte", v, 0);
    do_req(1, 5, TOT, 0, lat);
    chk("R5 column past end", lat, 1);
    rd(v); chk("R5 column past end empty", v, 0);

    // R4: erase block of page 6, page 8 in next block keeps data
    push(8'h00); push(8'h11); push(8'h22); push(8'h33);
    do_req(2, 8, 0, 0, lat);
    do_req(3, 6, 0, 0, lat);
    chk("R4 erase latency", lat, PPB*TOT);
    for (int p = 4; p < 8; p++) begin
      do_req(1, p, 0, 0, lat);
      for (int c = 0; c < TOT; c++) begin rd(v); chk("R4 erased byte", v, 255); end
    end

    // R7: out-of-range requests
    push(8'h00); push(8'h00);
    do_req(2, NP, 0, 0, lat);
    chk("R7 out of range program latency", lat, 1);
    do_req(1, 8, 0, 0, lat);
    rd(v); chk("R4 other block byte0", v, 8'h00);
    rd(v); chk("R4 other block byte1", v, 8'h11);
    do_req(1, NP + 4, 0, 0, lat);
    chk("R7 out of range load latency", lat, 1);
    rd(v); chk("R7 readout kept", v, 8'h22);
    do_req(3, 2*NP - 1, 0, 0, lat);
    rd(v); chk("R7 erase ignored readout", v, 8'h33);
    do_req(1, 8, 4, 0, lat);
    rd(v); chk("R7 out of range erase left array", v, 255);
    do_req(2, 9, 0, 0, lat);
    chk("R7 buffer kept latency", lat, 2);
    do_req(1, 9, 0, 0, lat);
    rd(v); chk("R7 kept byte0", v, 0);
    rd(v); chk("R7 kept byte1", v, 0);
    rd(v); chk("R7 byte2 untouched", v, 255);

    // R10: strobes and write bytes during an erase
    req_page = PGW'(12); req_col = '0; req_erase = 1'b1;
    @(negedge clk);
    req_erase = 1'b0;
    req_load = 1'b1; req_page = PGW'(9); wr_valid = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    req_load = 1'b0; wr_valid = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    chk("R10 erase latency unaffected", lat, PPB*TOT);
    @(negedge clk);
    chk("R10 no second done", int'(done), 0);
    do_req(2, 13, 0, 0, lat);
    chk("R10 buffer empty after busy write", lat, 1);
    do_req(1, 13, 0, 0, lat);
    rd(v); chk("R10 page untouched", v, 255);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule